// File: doc/BRIEF.md
# Multi-Mode 8x8 Multiplier Unit

This unit is the multiply engine of a small 8-bit processor datapath. A one-cycle start strobe hands it two byte operands and a 3-bit mode. The mode picks how each operand's sign is read and whether the product is treated as a fixed-point fraction. Two clock edges later the unit presents a 16-bit product as a high byte and a low byte, together with a zero flag and a carry flag. The product always goes to the same register pair, so the surrounding core needs no destination field for it.

One shared array serves all six variants. The first stage sign-extends each operand to the full product width, depending on the mode, and registers the extended operands. The second stage sums the partial products, applies the fractional one-bit left shift, derives the flags and registers the result. Results and flags keep their values until the next multiply completes.

Top module: `mul8_unit`

## Requirements
- R1: The low two bits of `mode` select the operand signs. 00 reads both operands as unsigned. 01 reads both as two's complement. 10 reads `opa` as two's complement and `opb` as unsigned. 11 behaves like 00. In every case `{prod_hi, prod_lo}` is the low 16 bits of the product.
- R2: When `mode[2]` is 1 the result is the 16-bit product shifted left by one place, and bit 0 of `prod_lo` is 0.
- R3: `prod_hi` always carries result bits 15..8 and `prod_lo` carries bits 7..0. No destination select exists.
- R4: A start sampled high at a rising edge while `busy` is low is accepted. After that edge `busy` is high for exactly one cycle. After the next edge `done` is high, `busy` is low, and the new result and flags are on the outputs.
- R5: `flag_c` equals bit 15 of the product before any fractional shift.
- R6: `flag_z` is 1 exactly when the final 16-bit result is zero.
- R7: A start that arrives while `busy` is high is ignored. Operand and mode changes after acceptance do not alter the result in progress.
- R8: `done` lasts one cycle. Result and flag outputs change only when `done` rises and hold their values otherwise.
- R9: While reset is asserted, and after it is released, `busy`, `done`, both product bytes and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| start | input | 1 | Request to begin a multiply |
| mode | input | 3 | Bit 2 selects fractional; bits 1..0 select the operand signs |
| opa | input | 8 | First operand (the signed one in the mixed mode) |
| opb | input | 8 | Second operand |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| prod_hi | output | 8 | Result bits 15..8 |
| prod_lo | output | 8 | Result bits 7..0 |
| flag_z | output | 1 | Result-is-zero flag |
| flag_c | output | 1 | Carry flag, bit 15 of the unshifted product |

## Verification
The timing properties assume that `start` stays low while the internal synchronized reset is still active. The bench therefore waits several cycles after releasing `rst_n` before it issues the first request. The fractional-LSB property assumes that `mode` is stable at the edge where a start is accepted. The bench drives every input at the falling edge, so each input is settled a half period before the edge that samples it. Extra starts are sent only in the busy cycle, which is where R7 defines their effect.

// File: rtl/mul8_pkg.sv
package mul8_pkg;

  localparam int MUL_W = 8;

  typedef enum logic [1:0] {
    SGN_UU  = 2'b00,
    SGN_SS  = 2'b01,
    SGN_SU  = 2'b10,
    SGN_ALT = 2'b11
  } sign_sel_e;

  typedef struct packed {
    logic a_signed;
    logic b_signed;
    logic frac;
  } mode_ctl_t;

  function automatic mode_ctl_t decode_mode(input logic [2:0] m);
    mode_ctl_t c;
    c.frac = m[2];
    unique case (sign_sel_e'(m[1:0]))
      SGN_SS:  begin c.a_signed = 1'b1; c.b_signed = 1'b1; end
      SGN_SU:  begin c.a_signed = 1'b1; c.b_signed = 1'b0; end
      default: begin c.a_signed = 1'b0; c.b_signed = 1'b0; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mul8_rstsync.sv
module mul8_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/mul8_opcond.sv
module mul8_opcond
  import mul8_pkg::*;
#(
  parameter int W = MUL_W,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  mode_ctl_t     ctl,
  output logic [PW-1:0] a_ext,
  output logic [PW-1:0] b_ext
);
  logic a_fill, b_fill;

  assign a_fill = ctl.a_signed & a[W-1];
  assign b_fill = ctl.b_signed & b[W-1];
  assign a_ext  = {{W{a_fill}}, a};
  assign b_ext  = {{W{b_fill}}, b};
endmodule

// File: rtl/mul8_array.sv
module mul8_array #(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic [PW-1:0] a_ext,
  input  logic [PW-1:0] b_ext,
  output logic [PW-1:0] prod
);
  logic [PW-1:0] pp [PW];

  for (genvar i = 0; i < PW; i++) begin : g_pp
    assign pp[i] = b_ext[i] ? (a_ext << i) : '0;
  end

  always_comb begin
    prod = '0;
    for (int k = 0; k < PW; k++) begin
      prod = prod + pp[k];
    end
  end
endmodule

// File: rtl/mul8_post.sv
module mul8_post #(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic [PW-1:0] raw,
  input  logic          frac,
  output logic [PW-1:0] result,
  output logic          zero,
  output logic          carry
);
  always_comb begin
    result = frac ? {raw[PW-2:0], 1'b0} : raw;
    carry  = raw[PW-1];
    zero   = ~|result;
  end
endmodule

// File: rtl/mul8_unit.sv
module mul8_unit
  import mul8_pkg::*;
#(
  parameter int W = MUL_W,
  localparam int PW = 2 * W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   mode,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo,
  output logic         flag_z,
  output logic         flag_c
);
  logic rst_int_n;

  mul8_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  // stage 1: operand conditioning
  mode_ctl_t     ctl;
  logic [PW-1:0] a_ext, b_ext;

  assign ctl = decode_mode(mode);

  mul8_opcond #(.W(W)) u_cond (
    .a     (opa),
    .b     (opb),
    .ctl   (ctl),
    .a_ext (a_ext),
    .b_ext (b_ext)
  );

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          ld_op, ld_res;
  logic [PW-1:0] a_q, b_q;
  logic          frac_q;

  always_comb begin
    ld_op  = start & ~busy_q;
    ld_res = busy_q;
    busy_d = ld_op;
    done_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_op) begin
      a_q    <= a_ext;
      b_q    <= b_ext;
      frac_q <= ctl.frac;
    end
  end

  // stage 2: array, shift, flags
  logic [PW-1:0] raw, res_d, res_q;
  logic          z_d, c_d, z_q, c_q;

  mul8_array #(.W(W)) u_arr (
    .a_ext (a_q),
    .b_ext (b_q),
    .prod  (raw)
  );

  mul8_post #(.W(W)) u_post (
    .raw    (raw),
    .frac   (frac_q),
    .result (res_d),
    .zero   (z_d),
    .carry  (c_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q <= '0;
      z_q   <= 1'b0;
      c_q   <= 1'b0;
    end else if (ld_res) begin
      res_q <= res_d;
      z_q   <= z_d;
      c_q   <= c_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign prod_hi = res_q[PW-1:W];
  assign prod_lo = res_q[W-1:0];
  assign flag_z  = z_q;
  assign flag_c  = c_q;
endmodule

// File: rtl/mul8_unit_chk.sv
module mul8_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [2:0]   mode,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] prod_hi,
  input logic [W-1:0] prod_lo,
  input logic         flag_z,
  input logic         flag_c
);
  a_r4_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r4_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done && !busy));

  a_r7_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !busy);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({prod_hi, prod_lo, flag_z, flag_c}));

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_z == ({prod_hi, prod_lo} == '0)));

  a_r2_frac_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode[2]) |-> ##2 (prod_lo[0] == 1'b0));
endmodule

bind mul8_unit mul8_unit_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .start   (start),
  .mode    (mode),
  .busy    (busy),
  .done    (done),
  .prod_hi (prod_hi),
  .prod_lo (prod_lo),
  .flag_z  (flag_z),
  .flag_c  (flag_c)
);

// File: tb/sim_mul8_unit.sv
module sim_mul8_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {mode, opa, opb, expected result, z, c}
  localparam logic [36:0] VEC [NVEC] = '{
    {3'd0, 8'hFF, 8'hFF, 16'hFE01, 1'b0, 1'b1},
    {3'd1, 8'h80, 8'h80, 16'h4000, 1'b0, 1'b0},
    {3'd2, 8'hFF, 8'hFF, 16'hFF01, 1'b0, 1'b1},
    {3'd4, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},
    {3'd5, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},
    {3'd6, 8'h80, 8'h02, 16'hFE00, 1'b0, 1'b1},
    {3'd4, 8'h00, 8'h37, 16'h0000, 1'b1, 1'b0},
    {3'd0, 8'h12, 8'h34, 16'h03A8, 1'b0, 1'b0},
    {3'd1, 8'h7F, 8'h81, 16'hC0FF, 1'b0, 1'b1},
    {3'd3, 8'h80, 8'h80, 16'h4000, 1'b0, 1'b0},
    {3'd7, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},
    {3'd2, 8'h01, 8'h80, 16'h0080, 1'b0, 1'b0}
  };
  localparam logic [7:0] CORNER [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [2:0] mode;
  logic [7:0] opa, opb;
  logic       busy, done, flag_z, flag_c;
  logic [7:0] prod_hi, prod_lo;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mul8_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .opa(opa), .opb(opb), .busy(busy), .done(done),
    .prod_hi(prod_hi), .prod_lo(prod_lo), .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] ref_mul(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
    int ia, ib, p;
    logic [15:0] raw, res;
    if (m[1:0] == 2'b01 || m[1:0] == 2'b10) ia = int'($signed(a)); else ia = int'(a);
    if (m[1:0] == 2'b01) ib = int'($signed(b)); else ib = int'(b);
    p   = ia * ib;
    raw = p[15:0];
    res = m[2] ? {raw[14:0], 1'b0} : raw;
    return {res, (res == 16'h0), raw[15]};
  endfunction

  // issue one multiply starting at a falling edge; leaves at the falling edge with done high
  task automatic do_op(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
    start = 1'b1; mode = m; opa = a; opb = b;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk("R4 busy after accept", {31'b0, busy}, 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R4 done at result", {30'b0, done, busy}, 32'b10);
  endtask

  task automatic cmp(input string req, input logic [17:0] exp);
    chk(req, {14'b0, prod_hi, prod_lo, flag_z, flag_c}, {14'b0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] keep;
    rst_n = 1'b0; start = 1'b0; mode = '0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset outputs", {12'b0, busy, done, prod_hi, prod_lo, flag_z, flag_c}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 idle after release", {12'b0, busy, done, prod_hi, prod_lo, flag_z, flag_c}, 32'h0);

    // table of directed vectors: R1 R2 R3 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      do_op(VEC[i][36:34], VEC[i][33:26], VEC[i][25:18]);
      cmp("R1/R2/R3/R5/R6 vector", VEC[i][17:0]);
    end

    // corners over all six modes plus the alias codes
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          do_op(3'(m), CORNER[i], CORNER[j]);
          cmp("R1 R2 R5 R6 corner", ref_mul(3'(m), CORNER[i], CORNER[j]));
        end
      end
    end

    // random operands
    for (int n = 0; n < 300; n++) begin
      logic [2:0] rm;
      logic [7:0] ra, rb;
      rm = 3'($urandom_range(0, 7));
      ra = 8'($urandom);
      rb = 8'($urandom);
      do_op(rm, ra, rb);
      cmp("R1 R2 random", ref_mul(rm, ra, rb));
    end

    // R7: start while busy is ignored, later operand changes have no effect
    start = 1'b1; mode = 3'd1; opa = 8'h7F; opb = 8'h7F;
    @(posedge clk); @(negedge clk);
    mode = 3'd0; opa = 8'hFF; opb = 8'hFF;   // start still high during busy
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    cmp("R7 captured operands", ref_mul(3'd1, 8'h7F, 8'h7F));
    @(posedge clk); @(negedge clk);
    chk("R7 no second op", {30'b0, busy, done}, 32'b00);
    cmp("R7 result kept", ref_mul(3'd1, 8'h7F, 8'h7F));

    // R8: done is a single pulse and results hold while idle
    do_op(3'd2, 8'h80, 8'hFF);
    keep = {prod_hi, prod_lo};
    mode = 3'd4; opa = 8'h01; opb = 8'h01;
    @(posedge clk); @(negedge clk);
    chk("R8 done one cycle", {31'b0, done}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R8 result held", {16'b0, prod_hi, prod_lo}, {16'b0, keep});
    cmp("R8 flags held", ref_mul(3'd2, 8'h80, 8'hFF));

    // R4: back-to-back request in the done cycle is accepted
    do_op(3'd0, 8'h02, 8'h03);
    do_op(3'd5, 8'hFF, 8'h01);
    cmp("R4 back-to-back", ref_mul(3'd5, 8'hFF, 8'h01));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule